// File: doc/BRIEF.md
# Flash Busy-Status Read Reporter

This block sits on the read-back path of a flash device model. While the device runs an internal program or erase, a read no longer returns array contents. Instead the block drives an encoded status word onto the data bus. One bit carries data-polling status and a neighbouring bit flips on each read strobe, so host software can tell when the operation has finished. When the device is idle, reads pass the array read port straight through.

The sequencer supplies a busy flag, the operation type and the last programmed word. The block counts the write strobes of the command sequence and reports status only once that sequence is long enough to have launched the operation: four strobes for a program, six for an erase. All strobes are active low and are sampled on the block clock. A strobe is detected on the clock edge that sees its transition.

Top module: `flash_status_reader`

## Requirements
- R1: While `busy` is low, `dqOut` equals `arrayData` on every bit.
- R2: While busy with a program (`isErase`=0) and at least PROG_STROBES write strobes counted, `dqOut[7]` is the inverse of `progData[7]`.
- R3: While busy with an erase (`isErase`=1) and at least ERASE_STROBES write strobes counted, `dqOut[7]` reads 0.
- R4: While status is reported, `dqOut[6]` inverts on each read strobe, which is a falling edge of `oeN` with `ceN` low. The first read of an operation shows 1, and successive reads alternate 1, 0, 1, 0 and so on.
- R5: While status is reported, every bit of `dqOut` other than bits 7 and 6 is 0.
- R6: While busy with too few write strobes for the operation type (fewer than 4 for a program, fewer than 6 for an erase), `dqOut` equals `arrayData`.
- R7: Once `busy` falls, reads return `arrayData` again, so bit 6 stops toggling. The write-strobe count is cleared on the clock after the fall, so a new operation needs a fresh strobe sequence.
- R8: The bit 6 toggle state returns to 0 on the clock after each rising edge of `busy`. The first read of every new operation therefore shows 1, whatever the previous operation left behind.
- R9: A write strobe is a rising edge of `weN` with `ceN` low. A rising edge of `weN` with `ceN` high is not counted.
- R10: After reset the write-strobe count and the toggle state are 0. If `busy` is then raised with no strobes, reads return `arrayData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable / read strobe, active low |
| weN | input | 1 | Write strobe, active low |
| busy | input | 1 | Internal program or erase in progress |
| isErase | input | 1 | Operation type: 1 for erase, 0 for program |
| progData | input | DATA_W | Last word programmed |
| arrayData | input | DATA_W | Array read port data |
| dqOut | output | DATA_W | Read data bus |

## Verification
The bench builds the block with its defaults: a 16-bit bus, a program threshold of four strobes and an erase threshold of six. Because the two thresholds differ, an erase launched after five strobes is a case that must stay in pass-through even though a program would already report status. The 16-bit bus also lets the bench check that the upper byte and the low six bits are held at zero alongside the two status bits.

// File: rtl/fbsr_pkg.sv
package fbsr_pkg;
  typedef struct packed {
    logic toggleClr;
    logic toggleFlip;
    logic statusSel;
  } fbsrStrobes_t;
endpackage

// File: rtl/fbsr_ctrl.sv
module fbsr_ctrl
  import fbsr_pkg::*;
#(
  parameter int PROG_STROBES  = 4,
  parameter int ERASE_STROBES = 6,
  parameter int CNT_W         = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ceN,
  input  logic             oeN,
  input  logic             weN,
  input  logic             busy,
  input  logic             isErase,
  output fbsrStrobes_t     strobes,
  output logic [CNT_W-1:0] wrCount
);
  localparam int CNT_MAX = (PROG_STROBES > ERASE_STROBES) ? PROG_STROBES : ERASE_STROBES;
  localparam logic [CNT_W-1:0] PROG_LIM  = CNT_W'(PROG_STROBES);
  localparam logic [CNT_W-1:0] ERASE_LIM = CNT_W'(ERASE_STROBES);
  localparam logic [CNT_W-1:0] SAT_LIM   = CNT_W'(CNT_MAX);

  logic oeNQ, weNQ, busyQ;
  logic rdFall, wrRise, busyRise, busyFall;
  logic countMet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oeNQ  <= 1'b1;
      weNQ  <= 1'b1;
      busyQ <= 1'b0;
    end else begin
      oeNQ  <= oeN;
      weNQ  <= weN;
      busyQ <= busy;
    end
  end

  assign rdFall   = oeNQ & ~oeN & ~ceN;
  assign wrRise   = ~weNQ & weN & ~ceN;
  assign busyRise = busy & ~busyQ;
  assign busyFall = ~busy & busyQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrCount <= '0;
    end else if (busyFall) begin
      wrCount <= '0;
    end else if (wrRise && !busy && wrCount < SAT_LIM) begin
      wrCount <= wrCount + 1'b1;
    end
  end

  assign countMet = isErase ? (wrCount >= ERASE_LIM) : (wrCount >= PROG_LIM);

  always_comb begin
    strobes.statusSel  = busy & countMet;
    strobes.toggleClr  = busyRise;
    strobes.toggleFlip = rdFall & busy & countMet;
  end
endmodule

// File: rtl/fbsr_datapath.sv
module fbsr_datapath
  import fbsr_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fbsrStrobes_t      strobes,
  input  logic              isErase,
  input  logic [DATA_W-1:0] progData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dqOut,
  output logic              toggleQ
);
  logic              pollBit;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toggleQ <= 1'b0;
    end else if (strobes.toggleClr) begin
      toggleQ <= 1'b0;
    end else if (strobes.toggleFlip) begin
      toggleQ <= ~toggleQ;
    end
  end

  assign pollBit = isErase ? 1'b0 : ~progData[POLL_BIT];

  for (genvar b = 0; b < DATA_W; b++) begin : g_status
    if (b == POLL_BIT) begin : g_poll
      assign statusWord[b] = pollBit;
    end else if (b == TOGGLE_BIT) begin : g_tog
      assign statusWord[b] = toggleQ;
    end else begin : g_zero
      assign statusWord[b] = 1'b0;
    end
  end

  assign dqOut = strobes.statusSel ? statusWord : arrayData;
endmodule

// File: rtl/flash_status_reader.sv
module flash_status_reader
  import fbsr_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int PROG_STROBES  = 4,
  parameter int ERASE_STROBES = 6,
  parameter int POLL_BIT      = 7,
  parameter int TOGGLE_BIT    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              busy,
  input  logic              isErase,
  input  logic [DATA_W-1:0] progData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dqOut
);
  localparam int CNT_MAX = (PROG_STROBES > ERASE_STROBES) ? PROG_STROBES : ERASE_STROBES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  fbsrStrobes_t     strobes;
  logic [CNT_W-1:0] wrCount;
  logic             toggleQ;

  fbsr_ctrl #(
    .PROG_STROBES (PROG_STROBES),
    .ERASE_STROBES(ERASE_STROBES),
    .CNT_W        (CNT_W)
  ) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .ceN    (ceN),
    .oeN    (oeN),
    .weN    (weN),
    .busy   (busy),
    .isErase(isErase),
    .strobes(strobes),
    .wrCount(wrCount)
  );

  fbsr_datapath #(
    .DATA_W    (DATA_W),
    .POLL_BIT  (POLL_BIT),
    .TOGGLE_BIT(TOGGLE_BIT)
  ) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .isErase  (isErase),
    .progData (progData),
    .arrayData(arrayData),
    .dqOut    (dqOut),
    .toggleQ  (toggleQ)
  );
endmodule

// File: rtl/flash_status_reader_chk.sv
module flash_status_reader_chk
  import fbsr_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int PROG_STROBES  = 4,
  parameter int ERASE_STROBES = 6,
  parameter int POLL_BIT      = 7,
  parameter int TOGGLE_BIT    = 6,
  parameter int CNT_W         = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              isErase,
  input logic [DATA_W-1:0] progData,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] dqOut,
  input logic [CNT_W-1:0]  wrCount,
  input logic              toggleQ,
  input fbsrStrobes_t      strobes
);
  localparam logic [DATA_W-1:0] OTHER_MASK =
    ~((DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT));
  localparam logic [CNT_W-1:0] PROG_LIM  = CNT_W'(PROG_STROBES);
  localparam logic [CNT_W-1:0] ERASE_LIM = CNT_W'(ERASE_STROBES);

  logic progReady, eraseReady;
  assign progReady  = busy && !isErase && wrCount >= PROG_LIM;
  assign eraseReady = busy && isErase && wrCount >= ERASE_LIM;

  p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dqOut == arrayData);

  p_prog_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
    progReady |-> dqOut[POLL_BIT] == ~progData[POLL_BIT]);

  p_erase_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eraseReady |-> dqOut[POLL_BIT] == 1'b0);

  p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.toggleFlip && !strobes.toggleClr) |=> toggleQ != $past(toggleQ));

  p_other_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (progReady || eraseReady) |-> (dqOut & OTHER_MASK) == '0);

  p_early_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !progReady && !eraseReady) |-> dqOut == arrayData);

  p_count_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> wrCount == '0);

  p_toggle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> toggleQ == 1'b0);
endmodule

bind flash_status_reader flash_status_reader_chk #(
  .DATA_W       (DATA_W),
  .PROG_STROBES (PROG_STROBES),
  .ERASE_STROBES(ERASE_STROBES),
  .POLL_BIT     (POLL_BIT),
  .TOGGLE_BIT   (TOGGLE_BIT),
  .CNT_W        (CNT_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .isErase  (isErase),
  .progData (progData),
  .arrayData(arrayData),
  .dqOut    (dqOut),
  .wrCount  (wrCount),
  .toggleQ  (toggleQ),
  .strobes  (strobes)
);

// File: tb/test_flash_status_reader.sv
module test_flash_status_reader;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic busy = 1'b0, isErase = 1'b0;
  logic [DW-1:0] progData = '0, arrayData = '0;
  logic [DW-1:0] dqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  flash_status_reader i_flash_status_reader (
    .clk(clk), .rst_n(rst_n), .ceN(ceN), .oeN(oeN), .weN(weN),
    .busy(busy), .isErase(isErase), .progData(progData),
    .arrayData(arrayData), .dqOut(dqOut)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] statusWord(input bit erase, input logic [DW-1:0] pd, input bit tog);
    logic [DW-1:0] w = '0;
    w[7] = erase ? 1'b0 : ~pd[7];
    w[6] = tog;
    return w;
  endfunction

  task automatic writeStrobes(input int n, input logic ce);
    for (int i = 0; i < n; i++) begin
      ceN = ce; weN = 1'b0;
      @(negedge clk); weN = 1'b1;
      @(negedge clk); ceN = 1'b1;
    end
  endtask

  task automatic readBus(output logic [DW-1:0] val);
    ceN = 1'b0; oeN = 1'b0;
    @(posedge clk); #2;
    val = dqOut;
    @(negedge clk); oeN = 1'b1; ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic startOp(input bit erase, input logic [DW-1:0] pd);
    isErase = erase; progData = pd; busy = 1'b1;
    @(negedge clk);
  endtask

  task automatic endOp;
    busy = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    arrayData = 16'h1234;
    startOp(1'b0, 16'h0080);
    readBus(v);
    check("R10 pass-through after reset", v, 16'h1234);
    endOp();
  endtask

  task automatic t_idle;
    logic [DW-1:0] v;
    logic [DW-1:0] pats [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h0040};
    foreach (pats[i]) begin
      arrayData = pats[i];
      readBus(v);
      check("R1 idle pass-through", v, pats[i]);
    end
  endtask

  task automatic t_program;
    logic [DW-1:0] v;
    arrayData = 16'hFFFF;
    writeStrobes(4, 1'b0);
    startOp(1'b0, 16'h00A5);
    for (int i = 0; i < 4; i++) begin
      arrayData = 16'hFFFF ^ DW'(i);
      readBus(v);
      check("R2 R4 R5 program status", v, statusWord(1'b0, 16'h00A5, (i % 2) == 0));
    end
    progData = 16'h0012;
    readBus(v);
    check("R2 program poll bit inverted", v, statusWord(1'b0, 16'h0012, 1'b1));
    endOp();
    arrayData = 16'h0040;
    readBus(v);
    check("R7 done read 1", v, 16'h0040);
    readBus(v);
    check("R7 done read 2 no toggle", v, 16'h0040);
  endtask

  task automatic t_erase;
    logic [DW-1:0] v;
    arrayData = 16'h5A5A;
    writeStrobes(6, 1'b0);
    startOp(1'b1, 16'h0080);
    for (int i = 0; i < 3; i++) begin
      readBus(v);
      check("R3 R4 R5 erase status", v, statusWord(1'b1, 16'h0080, (i % 2) == 0));
    end
    endOp();
    arrayData = 16'hFFFF;
    readBus(v);
    check("R7 erase done reads array", v, 16'hFFFF);
  endtask

  task automatic t_early;
    logic [DW-1:0] v;
    arrayData = 16'h3C3C;
    writeStrobes(3, 1'b0);
    startOp(1'b0, 16'h0000);
    readBus(v);
    check("R6 program with 3 strobes", v, 16'h3C3C);
    endOp();
    writeStrobes(5, 1'b0);
    startOp(1'b1, 16'h0000);
    readBus(v);
    check("R6 erase with 5 strobes", v, 16'h3C3C);
    endOp();
  endtask

  task automatic t_ceHigh;
    logic [DW-1:0] v;
    arrayData = 16'h0F0F;
    writeStrobes(4, 1'b1);
    startOp(1'b0, 16'h0000);
    readBus(v);
    check("R9 strobes with ceN high ignored", v, 16'h0F0F);
    endOp();
  endtask

  task automatic t_restart;
    logic [DW-1:0] v;
    arrayData = 16'h1111;
    writeStrobes(4, 1'b0);
    startOp(1'b0, 16'h0000);
    for (int i = 0; i < 3; i++) readBus(v);
    check("R4 third read shows 1", v, statusWord(1'b0, 16'h0000, 1'b1));
    endOp();
    startOp(1'b0, 16'h0000);
    readBus(v);
    check("R7 count cleared after op", v, 16'h1111);
    endOp();
    writeStrobes(4, 1'b0);
    startOp(1'b0, 16'h0080);
    readBus(v);
    check("R8 toggle restarts at first read", v, statusWord(1'b0, 16'h0080, 1'b1));
    endOp();
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    #1;
    check("R10 reset pass-through", dqOut, arrayData);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_program();
    t_erase();
    t_early();
    t_ceHigh();
    t_restart();
    done = 1'b1;
    finishRun();
  end
endmodule